// File: doc/BRIEF.md
# Secure Key ROM Slave

This block is a read-only memory target on a request/response bus that several CPU masters and one key-manager master share. Each request carries a master ID, a write flag and a word address. The matching response arrives on the following clock edge. It carries the same ID, an error flag and a data word. Reads return the stored word. Writes are refused with an error.

Two word addresses hold secret material, one encryption key and one decryption key. Only the key-manager ID may read them. A read of either address from any other ID gets an error.

Every error response and every idle cycle drives the data bus to zero. This means a word fetched by an earlier key read can never ride along with a later response to a CPU.

The memory contents are computed at elaboration. Word `a` is the low `DW` bits of the 32-bit product `(a + 1) * 0x85EBCA6B`, with `DW` no wider than 32. With the defaults, the encryption key sits at address 2, the decryption key at address 3, and the key-manager ID is all ones (3).

Top module: `srom_slave`

## Requirements
- R1: While reset is held and after it is released, before any request, `rsp_valid`, `rsp_err` and `rsp_data` are 0.
- R2: A read accepted from any ID at a non-key address produces a response on the next cycle with `rsp_err` = 0 and `rsp_data` equal to the stored word for that address.
- R3: A write accepted at any address produces a response on the next cycle with `rsp_err` = 1 and `rsp_data` = 0.
- R4: A read of the encryption-key or decryption-key address by the key-manager ID returns the stored key word with `rsp_err` = 0.
- R5: A read of either key address by an ID other than the key-manager ID returns `rsp_err` = 1 and `rsp_data` = 0.
- R6: Whenever `rsp_valid` is 0, `rsp_data` is 0.
- R7: While `rsp_valid` = 1 and `rsp_ready` = 0, `req_ready` is 0, and `rsp_valid`, `rsp_err`, `rsp_id` and `rsp_data` keep their values into the next cycle.
- R8: An error response that directly follows a key read by the key manager carries all-zero data, not the key.
- R9: `rsp_id` equals the `req_id` of the request that the response answers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write attempt, 0 = read |
| req_addr | input | AW | Word address |
| req_id | input | IW | Requesting master ID |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_err | output | 1 | Request refused (write or key access denied) |
| rsp_id | output | IW | ID echoed from the request |
| rsp_data | output | DW | Read word, zero on error or idle |

## Verification
Every response is due exactly one clock edge after its request handshake, or later only while `rsp_ready` holds it stalled. The bench drives inputs one time unit after the rising edge. It samples at the falling edge, and it compares a response only at the falling edge that precedes the edge on which the response is handed over.

A driver task pushes the expected ID, error flag and data word into a queue at the moment `req_ready` shows acceptance. A monitor pops the queue in order, which keeps the expectations aligned with the responses whatever the stall pattern is. Zero data on idle cycles is checked at every falling edge. Held values under a stall are compared one falling edge later.

// File: rtl/srom_pkg.sv
package srom_pkg;

  typedef enum logic [1:0] {
    ACC_READ     = 2'd0,
    ACC_WRITE    = 2'd1,
    ACC_KEY_DENY = 2'd2
  } access_e;

  // Contents generator: low bits of (a + 1) * 0x85EBCA6B
  function automatic logic [31:0] rom_word(input logic [31:0] a);
    return (a + 32'd1) * 32'h85EBCA6B;
  endfunction

endpackage

// File: rtl/srom_store.sv
module srom_store #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          clr,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  initial begin : fill_rom
    logic [31:0] w;
    for (int i = 0; i < DEPTH; i++) begin
      w = srom_pkg::rom_word(32'(i));
      mem[i] = w[DW-1:0];
    end
  end

  // Registered read port with synchronous clear (block RAM output register)
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (en) begin
      if (clr) q <= '0;
      else     q <= mem[addr];
    end
  end

endmodule

// File: rtl/srom_policy.sv
module srom_policy #(
  parameter int                AW           = 6,
  parameter int                IW           = 2,
  parameter logic [AW-1:0]     KEY_ENC_ADDR = AW'(2),
  parameter logic [AW-1:0]     KEY_DEC_ADDR = AW'(3),
  parameter logic [IW-1:0]     KM_ID        = '1
) (
  input  logic              write,
  input  logic [AW-1:0]     addr,
  input  logic [IW-1:0]     id,
  output srom_pkg::access_e kind
);
  logic key_hit;

  always_comb begin
    key_hit = (addr == KEY_ENC_ADDR) || (addr == KEY_DEC_ADDR);
    if (write)                       kind = srom_pkg::ACC_WRITE;
    else if (key_hit && id != KM_ID) kind = srom_pkg::ACC_KEY_DENY;
    else                             kind = srom_pkg::ACC_READ;
  end

endmodule

// File: rtl/srom_resp.sv
module srom_resp #(
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          advance,
  input  logic          accept,
  input  logic          err_in,
  input  logic [IW-1:0] id_in,
  output logic          valid,
  output logic          err,
  output logic [IW-1:0] id
);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      err   <= 1'b0;
      id    <= '0;
    end else if (advance) begin
      valid <= accept;
      err   <= accept & err_in;
      id    <= accept ? id_in : '0;
    end
  end

endmodule

// File: rtl/srom_slave.sv
module srom_slave #(
  parameter int            AW           = 6,
  parameter int            DW           = 32,
  parameter int            IW           = 2,
  parameter logic [AW-1:0] KEY_ENC_ADDR = AW'(2),
  parameter logic [AW-1:0] KEY_DEC_ADDR = AW'(3),
  parameter logic [IW-1:0] KM_ID        = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [IW-1:0] req_id,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic          rsp_err,
  output logic [IW-1:0] rsp_id,
  output logic [DW-1:0] rsp_data
);
  srom_pkg::access_e kind;
  logic accept;
  logic advance;
  logic grant_read;

  assign advance    = ~rsp_valid | rsp_ready;
  assign req_ready  = advance;
  assign accept     = req_valid & advance;
  assign grant_read = accept & (kind == srom_pkg::ACC_READ);

  srom_policy #(
    .AW(AW), .IW(IW),
    .KEY_ENC_ADDR(KEY_ENC_ADDR), .KEY_DEC_ADDR(KEY_DEC_ADDR), .KM_ID(KM_ID)
  ) u_policy (
    .write (req_write),
    .addr  (req_addr),
    .id    (req_id),
    .kind  (kind)
  );

  srom_store #(.AW(AW), .DW(DW)) u_store (
    .clk  (clk),
    .rst  (rst),
    .en   (advance),
    .clr  (~grant_read),
    .addr (req_addr),
    .q    (rsp_data)
  );

  srom_resp #(.IW(IW)) u_resp (
    .clk     (clk),
    .rst     (rst),
    .advance (advance),
    .accept  (accept),
    .err_in  (kind != srom_pkg::ACC_READ),
    .id_in   (req_id),
    .valid   (rsp_valid),
    .err     (rsp_err),
    .id      (rsp_id)
  );

  // R6
  idle_data_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> rsp_data == '0);

  // R3 R5 R8
  err_data_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> rsp_data == '0);

  // R3
  write_err_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_write) |=> (rsp_valid && rsp_err));

  // R5
  key_deny_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_write && req_id != KM_ID &&
     (req_addr == KEY_ENC_ADDR || req_addr == KEY_DEC_ADDR)) |=> (rsp_valid && rsp_err));

  // R9
  id_echo_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (rsp_valid && rsp_id == $past(req_id)));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_err) && $stable(rsp_id)));

  // R7
  stall_block_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |-> !req_ready);

endmodule

// File: tb/sim_srom_slave.sv
module sim_srom_slave;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam int IW = 2;
  localparam logic [IW-1:0] KM = 2'd3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr  = '0;
  logic [IW-1:0] req_id    = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic          rsp_err;
  logic [IW-1:0] rsp_id;
  logic [DW-1:0] rsp_data;

  srom_slave u0 (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_id(req_id),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_err(rsp_err),
    .rsp_id(rsp_id), .rsp_data(rsp_data)
  );

  typedef struct packed {
    logic          err;
    logic [IW-1:0] id;
    logic [DW-1:0] data;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];
  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;
  bit    stall_mode = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  function automatic logic [DW-1:0] word_at(input logic [AW-1:0] a);
    logic [31:0] p;
    p = ({26'd0, a} + 32'd1) * 32'h85EBCA6B;
    return p;
  endfunction

  function automatic bit key_addr(input logic [AW-1:0] a);
    return (a == 6'd2) || (a == 6'd3);
  endfunction

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // response backpressure
  always @(posedge clk) begin
    #1;
    if (stall_mode) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rsp_ready = lfsr[0];
    end else begin
      rsp_ready = 1'b1;
    end
  end

  task automatic issue(input logic w, input logic [AW-1:0] a,
                       input logic [IW-1:0] id, input string tag);
    exp_t e;
    e.id = id;
    if (w || (key_addr(a) && id != KM)) begin
      e.err = 1'b1; e.data = '0;
    end else begin
      e.err = 1'b0; e.data = word_at(a);
    end
    req_valid = 1'b1; req_write = w; req_addr = a; req_id = id;
    do @(negedge clk); while (!req_ready);
    expq.push_back(e);
    tagq.push_back(tag);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  // monitor / scoreboard
  logic          held_v = 1'b0;
  logic          held_err;
  logic [IW-1:0] held_id;
  logic [DW-1:0] held_data;

  always @(negedge clk) begin
    if (!rst && !done) begin
      if (held_v) begin
        checks++;
        if (!(rsp_valid && rsp_err == held_err && rsp_id == held_id && rsp_data == held_data)) begin
          fails++;
          $display("FAIL R7 stall hold: got v%0b e%0b id%0h d%08h expected v1 e%0b id%0h d%08h",
                   rsp_valid, rsp_err, rsp_id, rsp_data, held_err, held_id, held_data);
        end
      end
      held_v = rsp_valid && !rsp_ready;
      held_err = rsp_err; held_id = rsp_id; held_data = rsp_data;
      if (held_v) begin
        checks++;
        if (req_ready) begin
          fails++;
          $display("FAIL R7 req_ready during stall: got 1 expected 0");
        end
      end
      if (!rsp_valid) begin
        checks++;
        if (rsp_data != '0) begin
          fails++;
          $display("FAIL R6 idle data: got %08h expected 0", rsp_data);
        end
      end
      if (rsp_valid && rsp_ready) begin
        exp_t  e;
        string t;
        checks++;
        if (expq.size() == 0) begin
          fails++;
          $display("FAIL R9 unexpected response: got id%0h d%08h expected none", rsp_id, rsp_data);
        end else begin
          e = expq.pop_front();
          t = tagq.pop_front();
          if (rsp_err != e.err || rsp_id != e.id || rsp_data != e.data) begin
            fails++;
            $display("FAIL %s: got err%0b id%0h d%08h expected err%0b id%0h d%08h",
                     t, rsp_err, rsp_id, rsp_data, e.err, e.id, e.data);
          end
        end
      end
    end
  end

  initial begin
    repeat (30000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || rsp_err !== 1'b0 || rsp_data !== '0) begin
      fails++;
      $display("FAIL R1 reset: got v%0b e%0b d%08h expected 0 0 0", rsp_valid, rsp_err, rsp_data);
    end
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || rsp_data !== '0) begin
      fails++;
      $display("FAIL R1 after reset: got v%0b d%08h expected 0 0", rsp_valid, rsp_data);
    end
    @(posedge clk); #1;

    // R2 R9 plain reads from several IDs
    issue(1'b0, 6'd0,  2'd0, "R2");
    issue(1'b0, 6'd1,  2'd1, "R2");
    issue(1'b0, 6'd10, 2'd2, "R9");
    issue(1'b0, 6'd63, KM,   "R2");
    // R4 key reads by key manager
    issue(1'b0, 6'd2, KM, "R4");
    issue(1'b0, 6'd3, KM, "R4");
    // R5 key reads by CPUs
    issue(1'b0, 6'd2, 2'd0, "R5");
    issue(1'b0, 6'd3, 2'd1, "R5");
    // R3 writes
    issue(1'b1, 6'd5, 2'd1, "R3");
    issue(1'b1, 6'd2, KM,   "R3");
    // R8 error straight after a key read
    issue(1'b0, 6'd2, KM,   "R4");
    issue(1'b1, 6'd2, 2'd0, "R8");
    issue(1'b0, 6'd3, KM,   "R4");
    issue(1'b0, 6'd3, 2'd2, "R8");
    // R7 random backpressure across a mixed stream
    stall_mode = 1'b1;
    for (int i = 0; i < 200; i++) begin
      logic [AW-1:0] a;
      logic [IW-1:0] id;
      a  = AW'(i * 7);
      id = IW'(i);
      issue(i % 9 == 0, a, id, "R7");
    end
    stall_mode = 1'b0;
    repeat (10) @(posedge clk);
    if (expq.size() != 0) begin
      checks++;
      fails++;
      $display("FAIL R9 missing responses: got %0d pending expected 0", expq.size());
    end
    done = 1'b1;
    finish_run();
  end

endmodule